// File: doc/BRIEF.md
# Flash Block Lock Sequencer

This block sets or clears the lock bit on a contiguous range of blocks in a parallel NOR flash that uses the common command set. The caller gives a first and a last block index, the wanted lock state and the device feature byte, then pulses a request. The sequencer walks the range in ascending order. For each block it issues the lock-setup command and the lock or unlock command at the block base. It then confirms completion in one of two ways. If the device lacks instant per-block locking, it polls the status register. If the device has it, it enters identifier mode and reads back the block's lock bit.

A read-back that disagrees with the request makes the sequencer clear the status register, wait for ready and redo the same block. One retry counter serves the whole range, and too many retries abort the operation with an error. Commands go out on a simple single-cycle memory-bus master. Each command byte is placed on the byte lane that the configured bus width and byte order call for, and the lanes above the bus width are held at zero.

Top module: `blklock_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `bus_wr`, `bus_rd` and every bit of `prot` are 0.
- R2: For each block b, taken in ascending order from `blk_first` to `blk_last` inclusive, the sequencer writes 0x60 and then 0x01 (lock) or 0xD0 (unlock) to byte address b << BLK_SHIFT.
- R3: In little-endian mode the command byte sits in `bus_wdata[7:0]` and the status byte is taken from `bus_rdata[7:0]`. `bus_be` has its low BUS_BYTES bits set. Every data lane at or above BUS_BYTES is 0 on a write.
- R4: When bit 5 of `feat` is 0, each block completes by reading the status at the block base until bit 7 of the read byte is 1. Bit 0 is masked out, so a status of 0x01 counts as not ready. `bus_rdata` is used in the cycle after the `bus_rd` strobe.
- R5: If status polling does not see ready within CLK_HZ*POLL_MS/1000 cycles, the sequencer raises `err`, pulses `done` and touches no further block.
- R6: When bit 5 of `feat` is 1, each block completes by writing 0x90 to byte address 0x55*BUS_BYTES and reading byte address (b << BLK_SHIFT) + 2*BUS_BYTES. Bit 0 of that byte must equal the requested lock state.
- R7: Bit b of `prot` takes the requested lock state in the cycle that the lock or unlock command for block b is issued.
- R8: On a read-back mismatch, the sequencer writes 0x70 to byte address 0x55*BUS_BYTES. It reads status there until it sees ready or CLK_HZ*CLR_MS/1000 cycles pass, then redoes the same block from the 0x60 write.
- R9: One retry counter, cleared per request, is shared across the range. A mismatch that finds the counter already above MAX_RETRY (10) ends the operation with `err` after its 0x70 wait. With the default, the twelfth mismatch of a request aborts.
- R10: `req` is ignored while `busy` is 1.
- R11: A request with `blk_first` > `blk_last` completes with a `done` pulse and no bus access.
- R12: `done` is high for exactly one cycle at the end of an operation. `err` holds until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start pulse, taken only when idle |
| req_lock | input | 1 | 1 = lock the range, 0 = unlock it |
| blk_first | input | IDX_W | First block index |
| blk_last | input | IDX_W | Last block index |
| feat | input | 8 | Device feature byte; bit 5 selects read-back verify |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | DATA_W | Write data |
| bus_be | output | DATA_W/8 | Active byte lanes |
| bus_wr | output | 1 | Write strobe, one cycle |
| bus_rd | output | 1 | Read strobe, one cycle |
| bus_rdata | input | DATA_W | Read data, valid from the cycle after `bus_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Timeout or retry exhaustion, sticky |
| prot | output | NUM_BLK | Per-block protection flags |

## Verification
The bench puts ready-looking bytes on the upper read lanes and reports status 0x01 while the device is busy. A design that read the wrong lane, or that let bit 0 count as ready, would finish with too few status reads. A device model that ignores lock commands a set number of times checks the retry path. One case needs two retries and must finish clean. Another spreads twelve mismatches over two blocks; a per-block counter, or an off-by-one limit, would change the number of 0x70 writes or miss the error. A never-ready status checks that the timeout is honoured and that later blocks are skipped. An inverted range, and a request raised mid-operation, must cause no bus traffic beyond the expected sequence.

// File: rtl/blklock_pkg.sv
package blklock_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_SETUP, S_CMD, S_PRD, S_PEV,
      S_IDW, S_IDR, S_IDE, S_CLW, S_CLR, S_CLE,
      S_NEXT, S_END
   } seq_state_t;

   localparam logic [7:0] OP_SETUP  = 8'h60;
   localparam logic [7:0] OP_LOCK   = 8'h01;
   localparam logic [7:0] OP_UNLOCK = 8'hD0;
   localparam logic [7:0] OP_IDENT  = 8'h90;
   localparam logic [7:0] OP_CLRST  = 8'h70;

   localparam int FEAT_VERIFY = 5;
   localparam int STAT_READY  = 7;

   localparam int BANK_CMD_WORD = 'h55;
   localparam int LOCK_BIT_WORD = 2;

endpackage

// File: rtl/blklock_lane.sv
module blklock_lane #(
   parameter int DATA_W     = 32,
   parameter int BUS_BYTES  = 2,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [7:0]          op,
   input  logic [DATA_W-1:0]   rdata,
   output logic [DATA_W-1:0]   wdata,
   output logic [DATA_W/8-1:0] be,
   output logic [7:0]          rbyte
);
   localparam int LANES = DATA_W / 8;
   localparam int LANE  = BIG_ENDIAN ? BUS_BYTES - 1 : 0;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == LANE) begin : g_cmd
         assign wdata[8*i +: 8] = op;
      end else begin : g_zero
         assign wdata[8*i +: 8] = 8'h00;
      end
      assign be[i] = (i < BUS_BYTES);
   end

   assign rbyte = rdata[8*LANE +: 8];

endmodule

// File: rtl/blklock_tmr.sv
module blklock_tmr #(
   parameter int     CW        = 8,
   parameter longint LONG_LIM  = 100,
   parameter longint SHORT_LIM = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic sel_short,
   output logic expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (cnt != '1)    cnt <= cnt + 1'b1;
   end

   assign expired = sel_short ? (cnt >= CW'(SHORT_LIM)) : (cnt >= CW'(LONG_LIM));

endmodule

// File: rtl/blklock_seq.sv
module blklock_seq #(
   parameter int NUM_BLK    = 16,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int BUS_BYTES  = 2,
   parameter bit BIG_ENDIAN = 1'b0,
   parameter int BLK_SHIFT  = 8,
   parameter int CLK_HZ     = 100_000_000,
   parameter int POLL_MS    = 1400,
   parameter int CLR_MS     = 10,
   parameter int MAX_RETRY  = 10,
   localparam int IDX_W     = $clog2(NUM_BLK),
   localparam int LANES     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_lock,
   input  logic [IDX_W-1:0]  blk_first,
   input  logic [IDX_W-1:0]  blk_last,
   input  logic [7:0]        feat,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [LANES-1:0]  bus_be,
   output logic              bus_wr,
   output logic              bus_rd,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [NUM_BLK-1:0] prot
);
   import blklock_pkg::*;

   localparam longint POLL_CYC = (longint'(CLK_HZ) * POLL_MS) / 1000;
   localparam longint CLR_CYC  = (longint'(CLK_HZ) * CLR_MS) / 1000;
   localparam int     TCW      = $clog2(POLL_CYC + CLR_CYC + 2);
   localparam int     RTW      = $clog2(MAX_RETRY + 2);
   localparam logic [ADDR_W-1:0] BANK_CMD_ADR = ADDR_W'(BANK_CMD_WORD * BUS_BYTES);
   localparam logic [ADDR_W-1:0] LOCK_RD_OFS  = ADDR_W'(LOCK_BIT_WORD * BUS_BYTES);

   if (DATA_W % 8 != 0 || BUS_BYTES < 1 || BUS_BYTES > LANES) begin : g_bad_width
      $error("blklock_seq: BUS_BYTES must fit inside DATA_W byte lanes");
   end
   if (NUM_BLK < 2 || (1 << IDX_W) != NUM_BLK) begin : g_bad_blocks
      $error("blklock_seq: NUM_BLK must be a power of two of at least 2");
   end
   if (IDX_W + BLK_SHIFT > ADDR_W || BLK_SHIFT < 8) begin : g_bad_addr
      $error("blklock_seq: block address does not fit ADDR_W");
   end

   seq_state_t        st;
   logic [IDX_W-1:0]  cur, last_r;
   logic              lock_r, verify_r;
   logic [RTW-1:0]    retry;
   logic [7:0]        op, rbyte, stat_m;
   logic              tmr_clr, tmr_short, tmr_exp;
   logic [ADDR_W-1:0] blk_base;

   blklock_lane #(.DATA_W(DATA_W), .BUS_BYTES(BUS_BYTES), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .op(op), .rdata(bus_rdata), .wdata(bus_wdata), .be(bus_be), .rbyte(rbyte)
   );

   blklock_tmr #(.CW(TCW), .LONG_LIM(POLL_CYC), .SHORT_LIM(CLR_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .sel_short(tmr_short), .expired(tmr_exp)
   );

   assign stat_m    = rbyte & 8'hFE;
   assign blk_base  = ADDR_W'(cur) << BLK_SHIFT;
   assign tmr_clr   = (st == S_CMD) || (st == S_CLW);
   assign tmr_short = (st == S_CLR) || (st == S_CLE);
   assign busy      = (st != S_IDLE);
   assign done      = (st == S_END);

   always_comb begin
      op       = 8'h00;
      bus_addr = blk_base;
      bus_wr   = 1'b0;
      bus_rd   = 1'b0;
      unique case (st)
         S_SETUP: begin op = OP_SETUP; bus_wr = 1'b1; end
         S_CMD:   begin op = lock_r ? OP_LOCK : OP_UNLOCK; bus_wr = 1'b1; end
         S_PRD:   bus_rd = 1'b1;
         S_IDW:   begin op = OP_IDENT; bus_addr = BANK_CMD_ADR; bus_wr = 1'b1; end
         S_IDR:   begin bus_addr = blk_base + LOCK_RD_OFS; bus_rd = 1'b1; end
         S_CLW:   begin op = OP_CLRST; bus_addr = BANK_CMD_ADR; bus_wr = 1'b1; end
         S_CLR:   begin bus_addr = BANK_CMD_ADR; bus_rd = 1'b1; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cur      <= '0;
         last_r   <= '0;
         lock_r   <= 1'b0;
         verify_r <= 1'b0;
         retry    <= '0;
         err      <= 1'b0;
         prot     <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (req) begin
               err      <= 1'b0;
               cur      <= blk_first;
               last_r   <= blk_last;
               lock_r   <= req_lock;
               verify_r <= feat[FEAT_VERIFY];
               retry    <= '0;
               st       <= (blk_first > blk_last) ? S_END : S_SETUP;
            end
            S_SETUP: st <= S_CMD;
            S_CMD: begin
               prot[cur] <= lock_r;
               st        <= verify_r ? S_IDW : S_PRD;
            end
            S_PRD: st <= S_PEV;
            S_PEV: begin
               if (stat_m[STAT_READY])  st <= S_NEXT;
               else if (tmr_exp) begin  err <= 1'b1; st <= S_END; end
               else                     st <= S_PRD;
            end
            S_IDW: st <= S_IDR;
            S_IDR: st <= S_IDE;
            S_IDE: st <= (rbyte[0] == lock_r) ? S_NEXT : S_CLW;
            S_CLW: st <= S_CLR;
            S_CLR: st <= S_CLE;
            S_CLE: begin
               if (stat_m[STAT_READY] || tmr_exp) begin
                  if (retry > RTW'(MAX_RETRY)) begin
                     err <= 1'b1;
                     st  <= S_END;
                  end else begin
                     retry <= retry + 1'b1;
                     st    <= S_SETUP;
                  end
               end else begin
                  st <= S_CLR;
               end
            end
            S_NEXT: begin
               if (cur == last_r) st <= S_END;
               else begin
                  cur <= cur + 1'b1;
                  st  <= S_SETUP;
               end
            end
            S_END:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/blklock_seq_chk.sv
module blklock_seq_chk #(
   parameter int DATA_W    = 32,
   parameter int BUS_BYTES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata
);
   localparam int UPPER = 8 * BUS_BYTES;

   p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   p_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> ((bus_wdata >> UPPER) == '0));

   p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req) |=> $stable(err));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(bus_wr || bus_rd));

endmodule

bind blklock_seq blklock_seq_chk #(.DATA_W(DATA_W), .BUS_BYTES(BUS_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done), .err(err),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata)
);

// File: tb/blklock_seq_test.sv
module blklock_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int NB   = 16;
   localparam int IW   = 4;
   localparam int AW   = 16;
   localparam int DW   = 32;
   localparam int BB   = 2;
   localparam int SH   = 8;
   localparam int HZ   = 10_000;
   localparam int POLL_CYC = 14000;
   localparam int LOGN = 128;
   localparam logic [15:0] BANK_ADR = 16'h00AA;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, req_lock = 1'b0;
   logic [IW-1:0] blk_first = '0, blk_last = '0;
   logic [7:0] feat = '0;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic [DW/8-1:0] bus_be;
   logic bus_wr, bus_rd, busy, done, err;
   logic [NB-1:0] prot;

   blklock_seq #(.NUM_BLK(NB), .ADDR_W(AW), .DATA_W(DW), .BUS_BYTES(BB), .BIG_ENDIAN(1'b0),
                 .BLK_SHIFT(SH), .CLK_HZ(HZ), .POLL_MS(1400), .CLR_MS(10), .MAX_RETRY(10)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_lock(req_lock), .blk_first(blk_first),
      .blk_last(blk_last), .feat(feat), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .err(err), .prot(prot));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;

   // flash model state
   logic        lockst [NB];
   int          stuck  [NB];
   int          busy_reads = 0;
   logic        never_ready = 1'b0;
   logic        id_mode = 1'b0;
   logic [AW-1:0] wa [LOGN];
   logic [DW-1:0] wd [LOGN];
   logic [3:0]    wb [LOGN];
   logic [AW-1:0] ra [LOGN];
   int nw = 0, nrd = 0, n70 = 0;

   initial begin
      for (int i = 0; i < NB; i++) begin lockst[i] = 1'b0; stuck[i] = 0; end
      bus_rdata = '0;
   end

   always @(negedge clk) begin
      cyc++;
      if (bus_wr) begin
         if (nw < LOGN) begin wa[nw] = bus_addr; wd[nw] = bus_wdata; wb[nw] = bus_be; end
         nw++;
         case (bus_wdata[7:0])
            8'h90: id_mode = 1'b1;
            8'h70: begin id_mode = 1'b0; n70++; end
            8'h60: id_mode = 1'b0;
            8'h01, 8'hD0: begin
               if (stuck[bus_addr >> SH] > 0) stuck[bus_addr >> SH]--;
               else if (stuck[bus_addr >> SH] == 0) lockst[bus_addr >> SH] = (bus_wdata[7:0] == 8'h01);
            end
            default: ;
         endcase
      end
      if (bus_rd) begin
         if (nrd < LOGN) ra[nrd] = bus_addr;
         nrd++;
         if (id_mode) bus_rdata = {24'hA5A5A4, 7'h0, lockst[bus_addr >> SH]};
         else if (never_ready || busy_reads > 0) begin
            bus_rdata = {24'h818181, 8'h01};
            if (busy_reads > 0) busy_reads--;
         end else bus_rdata = {24'h010101, 8'h80};
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   always @(negedge clk) if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      summary();
   end

   task automatic start(input int f, input int l, input logic lk, input logic [7:0] ft);
      nw = 0; nrd = 0; n70 = 0;
      @(negedge clk);
      req = 1'b1; blk_first = IW'(f); blk_last = IW'(l); req_lock = lk; feat = ft;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_done(output int cycles);
      cycles = 1;
      while (!done && cycles < 40000) begin @(negedge clk); cycles++; end
      chk("R12 done seen", done, 1'b1);
      @(negedge clk);
      chk("R12 done one cycle", done, 1'b0);
      chk("R12 idle after done", busy, 1'b0);
   endtask

   task automatic chk_wr(input string rq, input int k, input logic [15:0] a, input logic [7:0] c);
      chk({rq, " addr"}, 32'(wa[k]), 32'(a));
      chk({rq, " data"}, wd[k], {24'h0, c});
      chk("R3 byte enables", 32'(wb[k]), 32'h3);
   endtask

   task automatic t_reset();
      chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
      chk("R1 prot", 32'(prot), 0); chk("R1 strobes", {bus_wr, bus_rd}, 0);
   endtask

   task automatic t_poll_lock();
      int c;
      busy_reads = 2;
      start(2, 4, 1'b1, 8'h00);
      wait_done(c);
      chk("R2 write count", nw, 6);
      for (int b = 2; b <= 4; b++) begin
         chk_wr("R2 setup", 2*(b-2), 16'(b << SH), 8'h60);
         chk_wr("R2 lock", 2*(b-2)+1, 16'(b << SH), 8'h01);
      end
      chk("R4 R3 status reads (bit0 busy, lane0)", nrd, 5);
      chk("R4 poll addr", 32'(ra[0]), 32'h0200);
      chk("R7 prot", 32'(prot), 32'h001C);
      chk("R12 err clear", err, 0);
   endtask

   task automatic t_timeout();
      int c;
      never_ready = 1'b1;
      start(5, 6, 1'b1, 8'h00);
      wait_done(c);
      never_ready = 1'b0;
      chk("R5 err", err, 1);
      chk("R5 no later block", nw, 2);
      chk("R5 waited full time", (c >= POLL_CYC), 1);
   endtask

   task automatic t_verify_unlock();
      int c;
      for (int i = 0; i < NB; i++) lockst[i] = 1'b1;
      start(3, 4, 1'b0, 8'h20);
      wait_done(c);
      chk("R6 write count", nw, 6);
      chk_wr("R6 setup", 0, 16'h0300, 8'h60);
      chk_wr("R6 unlock", 1, 16'h0300, 8'hD0);
      chk_wr("R6 ident", 2, BANK_ADR, 8'h90);
      chk_wr("R6 next block", 3, 16'h0400, 8'h60);
      chk("R6 reads", nrd, 2);
      chk("R6 lock-bit addr", 32'(ra[0]), 32'h0304);
      chk("R12 err cleared by new req", err, 0);
      chk("R7 prot", 32'(prot), 32'h0024);
   endtask

   task automatic t_retry();
      int c;
      for (int i = 0; i < NB; i++) lockst[i] = 1'b0;
      stuck[7] = 2;
      start(7, 7, 1'b1, 8'h20);
      wait_done(c);
      chk("R8 clear writes", n70, 2);
      chk("R8 total writes", nw, 11);
      chk_wr("R8 clear cmd", 3, BANK_ADR, 8'h70);
      chk_wr("R8 redo setup", 4, 16'h0700, 8'h60);
      chk("R8 err", err, 0);
      chk("R7 prot bit7", prot[7], 1);
   endtask

   task automatic t_abort();
      int c;
      stuck[8] = -1;
      start(8, 9, 1'b1, 8'h20);
      wait_done(c);
      chk("R9 clear writes", n70, 12);
      chk("R9 writes (no block 9)", nw, 48);
      chk("R9 err", err, 1);
      stuck[10] = 6; stuck[11] = 6;
      start(10, 11, 1'b1, 8'h20);
      wait_done(c);
      chk("R9 shared counter clear writes", n70, 12);
      chk("R9 shared counter err", err, 1);
   endtask

   task automatic t_busy_ignore();
      int c;
      start(12, 12, 1'b1, 8'h00);
      @(negedge clk);
      req = 1'b1; blk_first = 4'd0; blk_last = 4'd1;
      @(negedge clk);
      req = 1'b0;
      wait_done(c);
      chk("R10 writes", nw, 2);
      chk("R10 only block 12", 32'(wa[1]), 32'h0C00);
      repeat (3) @(negedge clk);
      chk("R10 no restart", busy, 0);
      chk("R12 err cleared", err, 0);
   endtask

   task automatic t_empty();
      start(6, 5, 1'b1, 8'h00);
      chk("R11 done at once", done, 1);
      @(negedge clk);
      chk("R11 done pulse", done, 0);
      chk("R11 no bus access", nw + nrd, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_poll_lock();
      t_timeout();
      t_verify_unlock();
      t_retry();
      t_abort();
      t_busy_ignore();
      t_empty();
      summary();
   end

endmodule